// File: doc/BRIEF.md
# Digital Silence Detector with Noise Test Output

This block watches a stereo sample stream one frame at a time and drives a single flag pin. In normal use the pin rises once both channels have carried samples that are exactly zero for a fixed number of consecutive frames. The pin is intended to switch an external mute device while the audio is digitally silent. Any frame that holds a nonzero value on either channel drops the pin in the same clock edge that takes the frame in.

The same pin serves as a test output. When the test mode input holds the value 7, the pin carries the output bit of an internal maximal-length linear feedback shift register (LFSR) instead of the silence flag. The LFSR advances only on cycles where a bit-rate enable is high; the system normally pulses this enable at 128 times the sample rate. The result is a long-period white-noise bit stream that can be filtered outside the block into a test signal.

Sample data is accepted only on cycles where the frame strobe is high. The run length, sample width, LFSR width, reset seed and test code are parameters. The defaults are 1024 frames, 24-bit samples, a 24-bit LFSR with seed 1, and code 7.

Top module: `quiet_detect_top`

## Requirements
- R1: With test mode not equal to 7, `flagOut` is 1 in the cycle after the strobed frame that completes RUN_LEN consecutive frames in which both samples equal zero. It is 0 after every shorter zero run.
- R2: A strobed frame with any nonzero bit in either `leftSample` or `rightSample` restarts the zero run at 0. `flagOut` (silence selection) reads 0 in the cycle after that frame.
- R3: Sample values on cycles where `frameValid` is 0 have no effect on the zero run or on `flagOut`.
- R4: The zero-run count saturates at RUN_LEN, so `flagOut` stays 1 through any number of further all-zero frames.
- R5: When `testMode` equals 7, `flagOut` is the LFSR output bit, which is the most significant state bit. Every other `testMode` value, including values that differ only in bits above bit 2 (for example 0x107 on a 9-bit input), selects the silence flag.
- R6: The LFSR changes state only at clock edges where `noiseTick` is 1. Each step shifts the state toward the most significant bit and loads bit 0 with the XOR of the tap bits. For width 24 the taps are bits 23, 22, 21 and 16. For width 8 they are bits 7, 5, 4 and 3.
- R7: Reset clears the zero run, so the silence flag is 0, and loads the LFSR with the seed value 1. The noise output is therefore 0 right after reset. It first reads 1 after LFSR_W−1 steps.
- R8: The LFSR sequence is maximal: its output repeats with period 2^LFSR_W − 1 steps, and each period contains 2^(LFSR_W−1) ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Strobe marking the cycle that carries one frame's samples |
| leftSample | input | SAMPLE_W | Left channel sample, two's complement |
| rightSample | input | SAMPLE_W | Right channel sample, two's complement |
| noiseTick | input | 1 | Bit-rate enable that advances the noise generator |
| testMode | input | TEST_W | Test register value; 7 selects the noise output |
| flagOut | output | 1 | Silence flag, or the noise bit in test mode 7 |

## Verification
The hardest conditions to reach from the ports are the exact boundary of the 1024-frame run and the full period of the noise sequence. The full 24-bit period is far beyond any practical run length. The bench therefore drives a second instance with an 8-frame run and an 8-bit LFSR next to the default one. It steps that instance through whole periods, counts the ones, and compares the sequence against its own repetition. The default instance is walked frame by frame through the 1023, 1024 and 1025 boundaries. A single set bit is then swept through every position of each channel to show that each one breaks the run.

// File: rtl/quiet_pkg.sv
package quiet_pkg;

  typedef struct packed {
    logic runStep;   // strobed frame with both samples zero
    logic runClear;  // strobed frame with a nonzero sample
    logic noiseStep; // advance the noise register
    logic noiseSel;  // route the noise bit to the pin
  } quietCtl_t;

  // Feedback tap masks for maximal-length Fibonacci registers
  function automatic logic [31:0] tapMask(input int unsigned width);
    case (width)
      8:       return 32'h0000_00B8;
      16:      return 32'h0000_D008;
      default: return 32'h00E1_0000;
    endcase
  endfunction

endpackage

// File: rtl/quiet_ctrl.sv
module quiet_ctrl
  import quiet_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned TEST_W     = 9,
  parameter int unsigned NOISE_CODE = 7
) (
  input  logic                frameValid,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                noiseTick,
  input  logic [TEST_W-1:0]   testMode,
  output quietCtl_t           ctl
);

  logic frameZero;

  always_comb begin
    frameZero     = (leftSample == '0) && (rightSample == '0);
    ctl.runStep   = frameValid && frameZero;
    ctl.runClear  = frameValid && !frameZero;
    ctl.noiseStep = noiseTick;
    ctl.noiseSel  = (testMode == TEST_W'(NOISE_CODE));
  end

endmodule

// File: rtl/quiet_dp.sv
module quiet_dp
  import quiet_pkg::*;
#(
  parameter int unsigned RUN_LEN = 1024,
  parameter int unsigned LFSR_W  = 24,
  parameter logic [LFSR_W-1:0] SEED = LFSR_W'(1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  quietCtl_t ctl,
  output logic      flagOut
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
  localparam logic [31:0] TAPS_FULL = tapMask(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS = TAPS_FULL[LFSR_W-1:0];

  logic [CNT_W-1:0]  runCount;
  logic [LFSR_W-1:0] noiseState;
  logic              feedBit;
  logic              silent;

  // zero-run counter, saturating at the run length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (ctl.runClear) begin
      runCount <= '0;
    end else if (ctl.runStep && (runCount != RUN_MAX)) begin
      runCount <= runCount + 1'b1;
    end
  end

  // Fibonacci noise register
  assign feedBit = ^(noiseState & TAPS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      noiseState <= SEED;
    end else if (ctl.noiseStep) begin
      noiseState <= {noiseState[LFSR_W-2:0], feedBit};
    end
  end

  assign silent  = (runCount == RUN_MAX);
  assign flagOut = ctl.noiseSel ? noiseState[LFSR_W-1] : silent;

endmodule

// File: rtl/quiet_detect_top.sv
module quiet_detect_top
  import quiet_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned TEST_W     = 9,
  parameter int unsigned NOISE_CODE = 7,
  parameter int unsigned RUN_LEN    = 1024,
  parameter int unsigned LFSR_W     = 24,
  parameter logic [LFSR_W-1:0] SEED = LFSR_W'(1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameValid,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                noiseTick,
  input  logic [TEST_W-1:0]   testMode,
  output logic                flagOut
);

  quietCtl_t ctl;

  quiet_ctrl #(
    .SAMPLE_W  (SAMPLE_W),
    .TEST_W    (TEST_W),
    .NOISE_CODE(NOISE_CODE)
  ) u_ctrl (
    .frameValid (frameValid),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .noiseTick  (noiseTick),
    .testMode   (testMode),
    .ctl        (ctl)
  );

  quiet_dp #(
    .RUN_LEN(RUN_LEN),
    .LFSR_W (LFSR_W),
    .SEED   (SEED)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .flagOut(flagOut)
  );

endmodule

// File: rtl/quiet_detect_chk.sv
module quiet_detect_chk #(
  parameter int unsigned SAMPLE_W   = 24,
  parameter int unsigned TEST_W     = 9,
  parameter int unsigned NOISE_CODE = 7,
  parameter int unsigned RUN_LEN    = 1024
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameValid,
  input logic [SAMPLE_W-1:0] leftSample,
  input logic [SAMPLE_W-1:0] rightSample,
  input logic                noiseTick,
  input logic [TEST_W-1:0]   testMode,
  input logic                flagOut
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [TEST_W-1:0] CODE = TEST_W'(NOISE_CODE);

  logic [CNT_W-1:0] zeroRunRef;
  logic             zeroFrame;
  logic             noiseMode;

  assign zeroFrame = (leftSample == '0) && (rightSample == '0);
  assign noiseMode = (testMode == CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroRunRef <= '0;
    end else if (frameValid) begin
      if (!zeroFrame) zeroRunRef <= '0;
      else if (zeroRunRef != CNT_W'(RUN_LEN)) zeroRunRef <= zeroRunRef + 1'b1;
    end
  end

  // R1 / R4: silence flag follows the saturating run window
  a_r1_run_len: assert property (@(posedge clk) disable iff (!rstN)
    !noiseMode |-> (flagOut == (zeroRunRef == CNT_W'(RUN_LEN))));

  // R2: a nonzero frame drops the flag at once
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!noiseMode && $past(frameValid && !zeroFrame)) |-> !flagOut);

  // R3: the flag can only rise after a strobed zero frame
  a_r3_rise_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    (!noiseMode && $past(!noiseMode) && $rose(flagOut)) |-> $past(frameValid && zeroFrame));

  // R4: flag held through idle cycles
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!noiseMode && $past(!noiseMode) && $past(flagOut) && !$past(frameValid)) |-> flagOut);

  // R6: noise output frozen without a tick
  a_r6_no_tick_stable: assert property (@(posedge clk) disable iff (!rstN)
    (noiseMode && $past(noiseMode) && !$past(noiseTick)) |-> $stable(flagOut));

endmodule

bind quiet_detect_top quiet_detect_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .TEST_W    (TEST_W),
  .NOISE_CODE(NOISE_CODE),
  .RUN_LEN   (RUN_LEN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .leftSample (leftSample),
  .rightSample(rightSample),
  .noiseTick  (noiseTick),
  .testMode   (testMode),
  .flagOut    (flagOut)
);

// File: tb/quiet_detect_top_bench.sv
module quiet_detect_top_bench;

  localparam int BIG_RUN   = 1024;
  localparam int SMALL_RUN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        noiseTick = 1'b0;
  logic [8:0]  testMode = '0;
  logic        flagBig, flagSmall;

  int nChecks = 0;
  int nFail = 0;
  int runBig = 0;
  int runSmall = 0;
  logic [23:0] lfsrBig;
  logic [7:0]  lfsrSmall;
  bit done = 0;

  always #10 clk = ~clk;

  quiet_detect_top u_quiet_detect_top (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .leftSample(leftSample), .rightSample(rightSample),
    .noiseTick(noiseTick), .testMode(testMode), .flagOut(flagBig)
  );

  quiet_detect_top #(.RUN_LEN(SMALL_RUN), .LFSR_W(8), .SEED(8'd1)) u_quiet_detect_top_small (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .leftSample(leftSample), .rightSample(rightSample),
    .noiseTick(noiseTick), .testMode(testMode), .flagOut(flagSmall)
  );

  function automatic logic [23:0] step24(input logic [23:0] s);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic [7:0] step8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    if (testMode == 9'd7) begin
      chk(req, flagBig, lfsrBig[23]);
      chk(req, flagSmall, lfsrSmall[7]);
    end else begin
      chk(req, flagBig, runBig >= BIG_RUN);
      chk(req, flagSmall, runSmall >= SMALL_RUN);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; frameValid = 1'b0; noiseTick = 1'b0;
    leftSample = '0; rightSample = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    runBig = 0; runSmall = 0;
    lfsrBig = 24'd1; lfsrSmall = 8'd1;
  endtask

  task automatic doFrame(input logic [23:0] l, input logic [23:0] r, input string req);
    @(negedge clk);
    frameValid = 1'b1; leftSample = l; rightSample = r;
    @(negedge clk);
    frameValid = 1'b0; leftSample = 24'hA5A5A5; rightSample = 24'h5A5A5A;
    if (l == 0 && r == 0) begin
      if (runBig < BIG_RUN) runBig++;
      if (runSmall < SMALL_RUN) runSmall++;
    end else begin
      runBig = 0; runSmall = 0;
    end
    checkFlags(req);
    @(negedge clk);
    checkFlags("R3 idle data ignored");
  endtask

  task automatic doTick(input string req);
    @(negedge clk);
    noiseTick = 1'b1;
    @(negedge clk);
    noiseTick = 1'b0;
    lfsrBig = step24(lfsrBig);
    lfsrSmall = step8(lfsrSmall);
    checkFlags(req);
  endtask

  initial begin
    bit seq [510];
    int ones;
    int rep;
    doReset();
    @(negedge clk);
    chk("R7 reset big flag", flagBig, 1'b0);
    chk("R7 reset small flag", flagSmall, 1'b0);

    // R1/R4: long zero run across both boundaries
    for (int i = 0; i < 1030; i++) doFrame('0, '0, "R1 zero run");
    chk("R4 saturated flag high", flagBig, 1'b1);

    // R2: single-bit sweep on each channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < 24; b++) begin
        for (int k = 0; k < SMALL_RUN; k++) doFrame('0, '0, "R1 small rebuild");
        if (ch == 0) doFrame(24'd1 << b, '0, "R2 left bit");
        else         doFrame('0, 24'd1 << b, "R2 right bit");
      end
    end
    doFrame(24'h800000, 24'h000001, "R2 both nonzero");

    // R5: mode selection
    for (int k = 0; k < SMALL_RUN; k++) doFrame('0, '0, "R1 small rebuild");
    foreach (testMode[i]) ;
    testMode = 9'd6;   @(negedge clk); checkFlags("R5 mode 6 silence");
    testMode = 9'h107; @(negedge clk); checkFlags("R5 mode 0x107 silence");
    testMode = 9'd15;  @(negedge clk); checkFlags("R5 mode 15 silence");
    testMode = 9'd7;   @(negedge clk); checkFlags("R5 mode 7 noise");

    // R6: sequence matches the tap rule; hold without ticks
    for (int i = 0; i < 2000; i++) begin
      doTick("R6 noise sequence");
      if (i % 97 == 0) begin
        repeat (3) @(negedge clk);
        checkFlags("R6 hold without tick");
      end
    end

    // R8: small instance period and balance
    for (int i = 0; i < 510; i++) begin
      doTick("R6 noise sequence");
      seq[i] = flagSmall;
    end
    ones = 0; rep = 0;
    for (int i = 0; i < 255; i++) begin
      if (seq[i]) ones++;
      if (seq[i] != seq[i + 255]) rep++;
    end
    nChecks++;
    if (ones != 128) begin nFail++; $display("FAIL R8 ones per period: got %0d expected 128", ones); end
    nChecks++;
    if (rep != 0) begin nFail++; $display("FAIL R8 period mismatch: got %0d expected 0", rep); end

    // R7: reset while in noise mode
    doReset();
    @(negedge clk);
    chk("R7 seed msb big", flagBig, 1'b0);
    chk("R7 seed msb small", flagSmall, 1'b0);
    for (int i = 0; i < 23; i++) doTick("R7 after seed");
    chk("R7 big msb after 23 steps", flagBig, 1'b1);
    testMode = 9'd0; @(negedge clk);
    chk("R7 silence flag cleared by reset", flagBig, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule